// File: doc/BRIEF.md
# SPI I/O Timing Skew Unit

This block sits between an SPI master's shift engine and the pads and adjusts timing on both data directions in units of the system clock. Outgoing serial data can be held back by zero to three cycles before it reaches the pad. Incoming serial data can likewise be delayed by zero to three cycles. The point at which the incoming bit is taken can be moved relative to the nominal sample strobe from the shift engine: two cycles earlier, one cycle earlier, on time, or one cycle later.

Early capture is made causal by delaying the nominal strobe by two cycles and then selecting from a short history of the delayed input. Every capture setting therefore reports its bit at the same fixed latency after the strobe. The three settings come from a 32-bit timing word. They are taken into the block only while no burst is running, so a new setting never splits a burst. The intended use is a later capture point at high bit rates and extra input delay at low bit rates with large clock dividers.

Top module: `spi_io_skew`

## Requirements
- R1: The output delay field, bits 17:16 of `tune_cfg`, sets N in 0..3. `pad_mosi` then equals the `core_mosi` value from N clock cycles earlier. With N = 0, `pad_mosi` follows `core_mosi` within the same cycle.
- R2: The input delay field, bits 19:18 of `tune_cfg`, sets M in 0..3. The internal delayed input used for capture is `pad_miso` from M cycles earlier.
- R3: The capture field, bits 21:20 of `tune_cfg`, selects the captured bit relative to the strobe cycle of the delayed input. Code 0 takes the bit from two cycles before the strobe, code 1 from one cycle before, code 2 from the strobe cycle itself, and code 3 from one cycle after.
- R4: `cap_valid` is high in exactly the cycles that come three clock cycles after a cycle in which `sample_stb` was high, for every capture setting.
- R5: `cap_data` changes only when a new capture is reported and holds its value between `cap_valid` pulses.
- R6: Reset (active-low `rst_n`) clears `cap_valid` and fills all delay stages and `cap_data` with the idle data level (parameter, default 1). The active settings reset to output delay 0, input delay 0 and capture code 2.
- R7: The three fields are loaded on each clock edge at which `burst_active` is low. While `burst_active` is high, changes to `tune_cfg` have no effect. A change takes effect from the edge after `burst_active` is seen low.
- R8: Bits of `tune_cfg` outside 21:16 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_cfg | input | 32 | Timing word holding the delay and capture fields |
| burst_active | input | 1 | High while a burst is in progress; freezes the settings |
| core_mosi | input | 1 | Outgoing serial bit from the shift engine |
| pad_mosi | output | 1 | Delayed outgoing bit to the pad |
| pad_miso | input | 1 | Incoming serial bit from the pad |
| sample_stb | input | 1 | Nominal capture strobe from the shift engine |
| cap_valid | output | 1 | Captured bit is presented this cycle |
| cap_data | output | 1 | Captured incoming bit |

## Verification
A wrong tap index or a stale setting shows up at the ports right away. On the output side, `pad_mosi` stops matching the stored history of `core_mosi` within the delay window. On the input side, `cap_data` disagrees with the expected history bit at the very next `cap_valid` pulse. A broken strobe pipeline moves or drops `cap_valid` three cycles after the strobe that caused it. A setting latched during a burst shifts `pad_mosi` mid-burst, and the bench catches this by comparing every cycle against a model that only loads settings when `burst_active` is low.

// File: rtl/spi_io_skew.sv
module spi_io_skew #(
  parameter int   CFG_W    = 32,
  parameter int   MO_LSB   = 16,
  parameter int   MI_LSB   = 18,
  parameter int   CAP_LSB  = 20,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] tune_cfg,
  input  logic             burst_active,
  input  logic             core_mosi,
  output logic             pad_mosi,
  input  logic             pad_miso,
  input  logic             sample_stb,
  output logic             cap_valid,
  output logic             cap_data
);
  localparam int MAXD = 3;

  logic [1:0]      mo_sel, mi_sel, cap_sel;
  logic [MAXD-1:0] mo_pipe, mi_pipe;
  logic [3:0]      hist;
  logic [1:0]      stb_pipe;
  logic            mi_now, tap;
  logic            unused_cfg_bits;

  assign unused_cfg_bits = ^tune_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mo_sel  <= 2'd0;
      mi_sel  <= 2'd0;
      cap_sel <= 2'd2;
    end else if (!burst_active) begin
      mo_sel  <= tune_cfg[MO_LSB+1:MO_LSB];
      mi_sel  <= tune_cfg[MI_LSB+1:MI_LSB];
      cap_sel <= tune_cfg[CAP_LSB+1:CAP_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mo_pipe <= {MAXD{IDLE_LVL}};
      mi_pipe <= {MAXD{IDLE_LVL}};
      hist    <= {4{IDLE_LVL}};
    end else begin
      mo_pipe <= {mo_pipe[MAXD-2:0], core_mosi};
      mi_pipe <= {mi_pipe[MAXD-2:0], pad_miso};
      hist    <= {hist[2:0], mi_now};
    end
  end

  assign pad_mosi = (mo_sel == 2'd0) ? core_mosi : mo_pipe[mo_sel - 2'd1];
  assign mi_now   = (mi_sel == 2'd0) ? pad_miso  : mi_pipe[mi_sel - 2'd1];
  assign tap      = hist[2'd3 - cap_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_pipe  <= 2'b00;
      cap_valid <= 1'b0;
      cap_data  <= IDLE_LVL;
    end else begin
      stb_pipe  <= {stb_pipe[0], sample_stb};
      cap_valid <= stb_pipe[1];
      if (stb_pipe[1]) cap_data <= tap;
    end
  end
endmodule

// File: rtl/spi_io_skew_chk.sv
module spi_io_skew_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       burst_active,
  input logic       core_mosi,
  input logic       pad_mosi,
  input logic       sample_stb,
  input logic       cap_valid,
  input logic [1:0] mo_sel,
  input logic [1:0] mi_sel,
  input logic [1:0] cap_sel
);
  logic [1:0] warm;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end
  assign ready = (warm == 2'd3);

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> ##3 cap_valid); // R4

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> ##3 !cap_valid); // R4

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |=> ($stable(mo_sel) && $stable(mi_sel) && $stable(cap_sel))); // R7

  AST_OUT_TWO_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && mo_sel == 2'd2) |-> (pad_mosi == $past(core_mosi, 2))); // R1
endmodule

bind spi_io_skew spi_io_skew_chk u_chk (
  .clk(clk), .rst_n(rst_n), .burst_active(burst_active),
  .core_mosi(core_mosi), .pad_mosi(pad_mosi), .sample_stb(sample_stb),
  .cap_valid(cap_valid), .mo_sel(mo_sel), .mi_sel(mi_sel), .cap_sel(cap_sel)
);

// File: tb/tb_spi_io_skew.sv
module tb_spi_io_skew;
  localparam int   CLK_PERIOD = 10;
  localparam int   NMAX       = 4096;
  localparam logic IDLE       = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tune_cfg = 32'h0;
  logic        burst_active = 1'b1;
  logic        core_mosi = IDLE;
  logic        pad_miso = IDLE;
  logic        sample_stb = 1'b0;
  logic        pad_mosi, cap_valid, cap_data;

  spi_io_skew #(.IDLE_LVL(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .tune_cfg(tune_cfg), .burst_active(burst_active),
    .core_mosi(core_mosi), .pad_mosi(pad_mosi), .pad_miso(pad_miso),
    .sample_stb(sample_stb), .cap_valid(cap_valid), .cap_data(cap_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    nchk = 0, nfail = 0, cyc = 0, stab = 0;
  bit    done = 0;
  logic  yh [NMAX];
  logic  xh [NMAX];
  logic  sh [NMAX];
  int    a_mo = 0, a_mi = 0, a_cap = 2;
  logic  exp_data = IDLE;
  bit    known = 1;
  string tag = "R6";

  function automatic logic hx(int j);
    return (j < 0) ? IDLE : xh[j];
  endfunction
  function automatic logic hy(int j);
    return (j < 0) ? IDLE : yh[j];
  endfunction
  function automatic logic hs(int j);
    return (j < 0) ? 1'b0 : sh[j];
  endfunction

  task automatic chk(logic got, logic exp, string req, string what);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s at cycle %0d: got %0b expected %0b", req, what, cyc, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic set_cfg(int mo, int mi, int cap);
    logic [31:0] r;
    r = $urandom;
    r[17:16] = mo[1:0];
    r[19:18] = mi[1:0];
    r[21:20] = cap[1:0];
    tune_cfg = r;
  endtask

  task automatic step(bit rnd_burst);
    logic ev;
    int   nm, ni, nc;
    core_mosi  = $urandom;
    pad_miso   = $urandom;
    sample_stb = ($urandom % 3) == 0;
    if (rnd_burst) burst_active = $urandom;
    yh[cyc] = core_mosi;
    xh[cyc] = pad_miso;
    sh[cyc] = sample_stb;
    #(CLK_PERIOD/4);
    chk(pad_mosi, hy(cyc - a_mo),
        (burst_active && tune_cfg[17:16] != a_mo[1:0]) ? "R7" : tag, "pad_mosi");
    ev = hs(cyc - 3);
    chk(cap_valid, ev, "R4", "cap_valid");
    if (ev) begin
      if (stab >= 8) begin
        exp_data = hx(cyc - 5 + a_cap - a_mi);
        known = 1;
        chk(cap_data, exp_data, tag, "cap_data");
      end else known = 0;
    end else if (known) begin
      chk(cap_data, exp_data, "R5", "cap_data hold");
    end
    @(posedge clk);
    nm = a_mo; ni = a_mi; nc = a_cap;
    if (!burst_active) begin
      nm = tune_cfg[17:16]; ni = tune_cfg[19:18]; nc = tune_cfg[21:20];
    end
    if (nm != a_mo || ni != a_mi || nc != a_cap) stab = 0;
    else if (stab < 100) stab++;
    a_mo = nm; a_mi = ni; a_cap = nc;
    cyc++;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(posedge clk);
    #1;
    chk(cap_valid, 1'b0, "R6", "cap_valid in reset");
    chk(cap_data, IDLE, "R6", "cap_data in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R6: burst held high, so the reset defaults (0,0,2) stay active
    tag = "R6";
    set_cfg(3, 3, 0);
    stab = 100;
    repeat (30) step(0);
    // R1 R2 R3: sweep every input delay and capture code
    tag = "R1 R2 R3";
    for (int mi = 0; mi < 4; mi++)
      for (int cp = 0; cp < 4; cp++) begin
        burst_active = 1'b0;
        set_cfg((mi + cp) % 4, mi, cp);
        repeat (2) step(0);
        repeat (50) step(1);
      end
    // R7: change while a burst runs is ignored until burst ends
    burst_active = 1'b0;
    set_cfg(1, 0, 1);
    repeat (12) step(0);
    burst_active = 1'b1;
    tag = "R7";
    set_cfg(3, 2, 3);
    repeat (30) step(0);
    burst_active = 1'b0;
    repeat (30) step(0);
    // R8: only unrelated bits move
    tag = "R8";
    for (int k = 0; k < 60; k++) begin
      set_cfg(2, 1, 0);
      step(0);
    end
    // random settings
    tag = "R1 R2 R3";
    for (int k = 0; k < 60; k++) begin
      set_cfg($urandom % 4, $urandom % 4, $urandom % 4);
      burst_active = 1'b0;
      step(0);
      repeat (15) step(1);
    end
    finish_run();
  end
endmodule